// File: doc/BRIEF.md
# Page-Mode Asynchronous SRAM Controller

This block is a clocked front end for an external asynchronous static RAM of 262,144 words of 16 bits. A client issues one request at a time over a valid/ready handshake. Each request carries a write flag, an 18-bit word address, 16 bits of write data and two byte enables. The controller drives the memory pins from registers and counts clock cycles to meet the memory's access, strobe and bus turnaround times. The pins it drives are two chip selects of opposite polarity, the write strobe, the output enable, two byte selects and the address. It also drives the data bus pads as an output value with an output enable, and it reads the pad input. Every read returns its word as a one-cycle response pulse.

The address splits into a page number in bits 17..4 and a word index in bits 3..0. A read that lands on the page left open by the previous read takes a short path, provided the byte enables match and no write came in between. The chip selects, the output enable and the byte selects stay asserted, the page bits stay fixed, and only the word index moves. This saves both time and supply current. A read to any other page, or with other byte enables, and every first read after a write, take a full read cycle. Before a write that follows a read, the bus is given back by deasserting the output enable and then waiting out a turnaround gap.

All timing values are parameters in clock cycles. The defaults suit a 100 MHz clock: a 7-cycle full read, a 3-cycle page read, a 4-cycle write strobe and a 2-cycle turnaround.

Top module: `sram_pg_ctrl`

## Requirements
- R1: After reset the memory is deselected (mem_ce1_n = 1, mem_ce2 = 0), mem_we_n = 1, mem_oe_n = 1, mem_ub_n = mem_lb_n = 1, mem_dq_oe = 0 and req_ready = 1.
- R2: A full read holds mem_addr steady and keeps mem_oe_n low from the acceptance edge on. rsp_valid rises exactly RD_CYC (7) clock edges after that edge. rsp_data is the word present on mem_dq_in in the cycle just before the rise.
- R3: A page hit is a read whose bits 17..4 and byte enables equal those of the previous request, which must itself have been a read. On a hit the chip selects, mem_oe_n and the byte selects stay asserted, only mem_addr[3:0] changes, and rsp_valid rises PAGE_CYC (3) edges after acceptance.
- R4: A read to a different page, or to the same page with different byte enables, takes the full RD_CYC latency.
- R5: A write drives mem_we_n low for exactly WR_CYC (4) cycles, with the memory selected and mem_addr steady. req_be[0] gives mem_lb_n = 0 (bits 7..0) and req_be[1] gives mem_ub_n = 0 (bits 15..8). mem_dq_out carries the write data with mem_dq_oe = 1 through the whole strobe and for one cycle after mem_we_n rises.
- R6: The first read after a write always takes the full RD_CYC latency, even on the page of an earlier read.
- R7: When a write follows a read, mem_oe_n is high for at least TA_CYC (2) cycles before mem_dq_oe rises, and mem_dq_oe is never 1 while mem_oe_n is 0.
- R8: In a read response, a byte lane whose enable was 0 returns 8'h00. An enabled lane returns the memory contents, including bytes left untouched by a partial write.
- R9: req_ready is 0 from the cycle after a request is accepted until its cycle ends. Each read gives exactly one single-cycle rsp_valid pulse, during which req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: bits 17..4 page, 3..0 word |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 16 | Read word, disabled lanes zero |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus pad drive enable |
| mem_dq_in | input | 16 | Data bus pad input |

## Verification
The bench places a memory model on the pins. The model returns garbage until the address has been steady for the full access time, or for the page access time when only the word index moved under a held page. A controller that samples early, or that wrongly treats a miss, a byte-enable change or a read after a write as a page hit, therefore returns wrong words or shows the wrong latency. The model checks the strobe length, that the drivers stay on after the strobe, and the turnaround gap before a write that follows a read. A controller that released the bus early or drove into the memory's output would corrupt stored words or be reported directly. Partial writes followed by reads with fewer lanes enabled expose lane mixing and missing zero masking, and reads at the top address and across all sixteen words of one page cover the address edges.

// File: rtl/sram_pg_pkg.sv
package sram_pg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_TURN,
      ST_WRITE,
      ST_HOLD
   } ctl_state_e;
endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_page_track.sv
module sram_page_track #(
   parameter int PAGE_W = 14,
   parameter int BE_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [BE_W-1:0]   be_i,
   output logic              open_o,
   output logic              hit_o
);
   logic [PAGE_W-1:0] page_q;
   logic [BE_W-1:0]   be_q;
   logic              open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         page_q <= '0;
         be_q   <= '0;
      end else if (set_i) begin
         open_q <= 1'b1;
         page_q <= page_i;
         be_q   <= be_i;
      end else if (clr_i) begin
         open_q <= 1'b0;
      end
   end

   assign open_o = open_q;
   assign hit_o  = open_q && (page_i == page_q) && (be_i == be_q);
endmodule

// File: rtl/sram_pg_ctrl.sv
module sram_pg_ctrl
   import sram_pg_pkg::*;
#(
   parameter int ADDR_W         = 18,
   parameter int DATA_W         = 16,
   parameter int WORD_BITS      = 4,
   parameter int RD_CYC         = 7,
   parameter int PAGE_CYC       = 3,
   parameter int WR_CYC         = 4,
   parameter int TA_CYC         = 2,
   parameter bit ZERO_OFF_LANES = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W/8-1:0]    req_be,
   output logic                   rsp_valid,
   output logic [DATA_W-1:0]      rsp_data,
   output logic                   mem_ce1_n,
   output logic                   mem_ce2,
   output logic                   mem_we_n,
   output logic                   mem_oe_n,
   output logic                   mem_ub_n,
   output logic                   mem_lb_n,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_dq_out,
   output logic                   mem_dq_oe,
   input  logic [DATA_W-1:0]      mem_dq_in
);
   localparam int BE_W    = DATA_W / 8;
   localparam int PAGE_W  = ADDR_W - WORD_BITS;
   localparam int MAX_A   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
   localparam int MAX_CYC = (MAX_A > TA_CYC) ? MAX_A : TA_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (BE_W != 2 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("sram_pg_ctrl: data bus must be two byte lanes");
   end
   if (WORD_BITS < 1 || WORD_BITS >= ADDR_W) begin : g_bad_page
      $error("sram_pg_ctrl: word index must leave page bits");
   end
   if (PAGE_CYC < 1 || PAGE_CYC > RD_CYC || WR_CYC < 1 || TA_CYC < 1) begin : g_bad_timing
      $error("sram_pg_ctrl: timing parameters out of range");
   end

   ctl_state_e        state_q;
   logic              sel_q, we_n_q, oe_n_q, dq_oe_q;
   logic [BE_W-1:0]   byte_n_q;
   logic [ADDR_W-1:0] addr_q, wr_addr_q;
   logic [DATA_W-1:0] dq_out_q, wr_data_q, rd_word;
   logic [BE_W-1:0]   wr_be_q;

   logic              accept, t_zero, t_load, pg_open, pg_hit;
   logic [CNT_W-1:0]  t_val;
   logic [ADDR_W-1:0] w_addr;
   logic [DATA_W-1:0] w_data;
   logic [BE_W-1:0]   w_be;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   sram_page_track #(.PAGE_W(PAGE_W), .BE_W(BE_W)) u_page (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (accept && !req_write),
      .clr_i  (accept && req_write),
      .page_i (req_addr[ADDR_W-1:WORD_BITS]),
      .be_i   (req_be),
      .open_o (pg_open),
      .hit_o  (pg_hit)
   );

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      if (accept) begin
         t_load = 1'b1;
         if (!req_write)
            t_val = pg_hit ? CNT_W'(PAGE_CYC - 1) : CNT_W'(RD_CYC - 1);
         else
            t_val = pg_open ? CNT_W'(TA_CYC - 1) : CNT_W'(WR_CYC - 1);
      end else if (state_q == ST_TURN && t_zero) begin
         t_load = 1'b1;
         t_val  = CNT_W'(WR_CYC - 1);
      end
   end

   sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   // write source: straight from the request, or from the parked copy after turnaround
   assign w_addr = (state_q == ST_TURN) ? wr_addr_q : req_addr;
   assign w_data = (state_q == ST_TURN) ? wr_data_q : req_wdata;
   assign w_be   = (state_q == ST_TURN) ? wr_be_q   : req_be;

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      if (ZERO_OFF_LANES) begin : g_mask
         assign rd_word[g*8 +: 8] = byte_n_q[g] ? 8'h00 : mem_dq_in[g*8 +: 8];
      end else begin : g_pass
         assign rd_word[g*8 +: 8] = mem_dq_in[g*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         sel_q     <= 1'b0;
         we_n_q    <= 1'b1;
         oe_n_q    <= 1'b1;
         byte_n_q  <= '1;
         addr_q    <= '0;
         dq_out_q  <= '0;
         dq_oe_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
         wr_be_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept && !req_write) begin
                  addr_q   <= req_addr;
                  sel_q    <= 1'b1;
                  oe_n_q   <= 1'b0;
                  byte_n_q <= ~req_be;
                  state_q  <= ST_READ;
               end else if (accept) begin
                  wr_addr_q <= req_addr;
                  wr_data_q <= req_wdata;
                  wr_be_q   <= req_be;
                  if (pg_open) begin
                     oe_n_q   <= 1'b1;
                     byte_n_q <= '1;
                     state_q  <= ST_TURN;
                  end else begin
                     addr_q   <= w_addr;
                     sel_q    <= 1'b1;
                     we_n_q   <= 1'b0;
                     byte_n_q <= ~w_be;
                     dq_out_q <= w_data;
                     dq_oe_q  <= 1'b1;
                     state_q  <= ST_WRITE;
                  end
               end
            end
            ST_READ: begin
               if (t_zero) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= rd_word;
                  state_q   <= ST_IDLE;
               end
            end
            ST_TURN: begin
               if (t_zero) begin
                  addr_q   <= w_addr;
                  sel_q    <= 1'b1;
                  we_n_q   <= 1'b0;
                  byte_n_q <= ~w_be;
                  dq_out_q <= w_data;
                  dq_oe_q  <= 1'b1;
                  state_q  <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (t_zero) begin
                  we_n_q  <= 1'b1;
                  state_q <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               dq_oe_q  <= 1'b0;
               sel_q    <= 1'b0;
               byte_n_q <= '1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_ce1_n  = ~sel_q;
   assign mem_ce2    = sel_q;
   assign mem_we_n   = we_n_q;
   assign mem_oe_n   = oe_n_q;
   assign mem_lb_n   = byte_n_q[0];
   assign mem_ub_n   = byte_n_q[BE_W-1];
   assign mem_addr   = addr_q;
   assign mem_dq_out = dq_out_q;
   assign mem_dq_oe  = dq_oe_q;
endmodule

// File: rtl/sram_pg_ctrl_chk.sv
module sram_pg_ctrl_chk #(
   parameter int ADDR_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce1_n,
   input logic              mem_ce2,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_dq_oe
);
   p_strobe_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce1_n && mem_ce2));

   p_strobe_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   p_release_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_dq_oe);

   p_wr_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

   p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   p_rd_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready) && !mem_oe_n) |-> $stable(mem_addr));

   p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_rsp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);
endmodule

bind sram_pg_ctrl sram_pg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_ce1_n (mem_ce1_n),
   .mem_ce2   (mem_ce2),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_addr  (mem_addr),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_pg_ctrl_tb.sv
module sram_pg_ctrl_tb;
   localparam int RD = 7;
   localparam int PG = 3;
   localparam int WR = 4;
   localparam int TA = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic req_ready, rsp_valid;
   logic [15:0] rsp_data;
   logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
   logic [17:0] mem_addr;
   logic [15:0] mem_dq_out, mem_dq_in;

   always #5 clk = ~clk;

   sram_pg_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] init_word(logic [17:0] a);
      return a[15:0] ^ 16'h5AC3;
   endfunction

   // ---------------- memory model on the pins ----------------
   logic [15:0] model_mem [int];
   logic [17:0] m_prev = '0, m_waddr = '0;
   logic        m_open = 1'b0, m_prev_we_n = 1'b1, m_prev_dqoe = 1'b0;
   int          m_cnt = 0, m_need = RD, m_quiet = 100, m_wlow = 0;
   logic [15:0] m_wdat = '0;
   logic [1:0]  m_wbe = '0;
   int          chk_m = 0, fail_m = 0;
   logic        m_sel;
   assign m_sel = !mem_ce1_n && mem_ce2;

   function automatic logic [15:0] model_rd(logic [17:0] a);
      if (model_mem.exists(int'(a))) return model_mem[int'(a)];
      return init_word(a);
   endfunction

   always @* begin
      logic [15:0] w;
      w = model_rd(mem_addr);
      if (m_sel && !mem_oe_n && mem_we_n && m_open && m_cnt >= m_need - 1)
         mem_dq_in = {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'h5A : w[7:0]};
      else
         mem_dq_in = 16'hEEEE;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         logic [15:0] w;
         // read access tracking
         if (!(m_sel && !mem_oe_n && mem_we_n)) begin
            m_open <= 1'b0;
            m_cnt  <= 0;
         end else if (!m_open || mem_addr != m_prev) begin
            m_need <= (m_open && mem_addr[17:4] == m_prev[17:4]) ? PG : RD;
            m_cnt  <= 1;
            m_open <= 1'b1;
         end else if (m_cnt < 50) begin
            m_cnt <= m_cnt + 1;
         end
         m_prev <= mem_addr;
         // write strobe
         if (m_sel && !mem_we_n) begin
            m_wlow  <= m_wlow + 1;
            m_wdat  <= mem_dq_out;
            m_wbe   <= {!mem_ub_n, !mem_lb_n};
            m_waddr <= mem_addr;
            chk_m++;
            if (!mem_dq_oe) begin
               fail_m++;
               $display("FAIL R5: data not driven during strobe, dq_oe=%0b expected 1", mem_dq_oe);
            end
         end
         if (!m_prev_we_n && mem_we_n) begin
            chk_m++;
            if (m_wlow != WR) begin
               fail_m++;
               $display("FAIL R5: strobe length %0d expected %0d", m_wlow, WR);
            end
            chk_m++;
            if (!mem_dq_oe) begin
               fail_m++;
               $display("FAIL R5: drivers off at strobe end, dq_oe=%0b expected 1", mem_dq_oe);
            end
            w = model_rd(m_waddr);
            if (m_wbe[0]) w[7:0]  = m_wdat[7:0];
            if (m_wbe[1]) w[15:8] = m_wdat[15:8];
            model_mem[int'(m_waddr)] = w;
            m_wlow <= 0;
         end
         m_prev_we_n <= mem_we_n;
         // turnaround
         if (mem_dq_oe && !m_prev_dqoe) begin
            chk_m++;
            if (m_quiet < TA) begin
               fail_m++;
               $display("FAIL R7: drivers on after %0d quiet cycles expected >= %0d", m_quiet, TA);
            end
         end
         m_prev_dqoe <= mem_dq_oe;
         if (!mem_oe_n) m_quiet <= 0;
         else if (m_quiet < 100) m_quiet <= m_quiet + 1;
      end
   end

   // ---------------- scoreboard ----------------
   logic [15:0] q_dat[$];
   int          q_lat[$];
   int          q_t0[$];
   string       q_tag[$];
   int          chk_mon = 0, fail_mon = 0;
   logic        prev_rv = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_rv && rsp_valid) begin
            chk_mon++; fail_mon++;
            $display("FAIL R9: rsp_valid held two cycles, actual 1 expected 0");
         end
         if (rsp_valid) begin
            if (q_dat.size() == 0) begin
               chk_mon++; fail_mon++;
               $display("FAIL R9: unexpected response data=%h expected none", rsp_data);
            end else begin
               logic [15:0] ed; int el, et; string tg;
               ed = q_dat.pop_front(); el = q_lat.pop_front();
               et = q_t0.pop_front();  tg = q_tag.pop_front();
               chk_mon++;
               if (rsp_data !== ed) begin
                  fail_mon++;
                  $display("FAIL %s: read data actual=%h expected=%h", tg, rsp_data, ed);
               end
               chk_mon++;
               if (cyc - et != el) begin
                  fail_mon++;
                  $display("FAIL %s: read latency actual=%0d expected=%0d", tg, cyc - et, el);
               end
               chk_mon++;
               if (!req_ready) begin
                  fail_mon++;
                  $display("FAIL R9: ready during response actual=0 expected=1");
               end
            end
         end
         prev_rv <= rsp_valid;
      end
   end

   // ---------------- driver ----------------
   logic [15:0] shadow [int];
   logic        last_rd = 1'b0;
   logic [13:0] last_page = '0;
   logic [1:0]  last_be = '0;
   int          checks = 0, failures = 0;
   logic        finished = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(logic [17:0] a, logic [1:0] be);
      logic [15:0] w;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
      if (!be[0]) w[7:0]  = 8'h00;   // R8 lane masking
      if (!be[1]) w[15:8] = 8'h00;
      return w;
   endfunction

   task automatic handshake(input logic wr, input logic [17:0] a, input logic [15:0] d,
                            input logic [1:0] be, output int t0);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      t0 = cyc;
      req_valid = 1'b0;
      check("R9 ready low after accept", {31'b0, req_ready}, 32'd0);
   endtask

   task automatic do_read(input logic [17:0] a, input logic [1:0] be, input string tag);
      logic hit; int t0;
      hit = last_rd && (a[17:4] == last_page) && (be == last_be);
      q_dat.push_back(exp_word(a, be));
      q_lat.push_back(hit ? PG : RD);
      q_t0.push_back(0);
      q_tag.push_back(tag);
      handshake(1'b0, a, 16'h0, be, t0);
      q_t0[q_t0.size() - 1] = t0;
      if (hit) begin
         // R3: selects and output enable held, address moved to new word
         check("R3 selects held", {29'b0, mem_ce1_n, mem_ce2, mem_oe_n}, {29'b0, 3'b010});
         check("R3 page address", {14'b0, mem_addr}, {14'b0, a});
      end
      last_rd = 1'b1; last_page = a[17:4]; last_be = be;
   endtask

   task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
      logic [15:0] w; int t0;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
      handshake(1'b1, a, d, be, t0);
      last_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ce1_n", {31'b0, mem_ce1_n}, 32'd1);
      check("R1 ce2", {31'b0, mem_ce2}, 32'd0);
      check("R1 we_n/oe_n", {30'b0, mem_we_n, mem_oe_n}, 32'd3);
      check("R1 byte selects", {30'b0, mem_ub_n, mem_lb_n}, 32'd3);
      check("R1 dq_oe", {31'b0, mem_dq_oe}, 32'd0);
      check("R1 ready", {31'b0, req_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after release", {31'b0, req_ready}, 32'd1);

      do_read(18'h12340, 2'b11, "R2");
      do_read(18'h12345, 2'b11, "R3");
      do_read(18'h1234F, 2'b11, "R3");
      do_read(18'h12350, 2'b11, "R4");
      do_read(18'h12351, 2'b01, "R4");
      do_write(18'h00010, 16'hBEEF, 2'b11);   // R7 turnaround from open page
      do_write(18'h00011, 16'h1234, 2'b10);   // R5 upper lane only
      do_read(18'h00010, 2'b11, "R6");
      do_read(18'h00011, 2'b11, "R8");
      do_read(18'h00011, 2'b10, "R8");
      do_write(18'h3FFFF, 16'hCAFE, 2'b01);
      do_read(18'h3FFFF, 2'b11, "R6");
      do_read(18'h3FFFF, 2'b01, "R8");
      for (int i = 0; i < 16; i++) do_write(18'h00100 + 18'(i), 16'h0F00 + 16'(i * 17), 2'b11);
      for (int i = 0; i < 16; i++) do_read(18'h00100 + 18'(i), 2'b11, (i == 0) ? "R6" : "R3");
      do_read(18'h00110, 2'b11, "R4");
      repeat (12) @(negedge clk);
      check("R9 all responses seen", q_dat.size(), 32'd0);
      check("R1 idle ready", {31'b0, req_ready}, 32'd1);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks + chk_m + chk_mon,
               failures + fail_m + fail_mon);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog: run hung, actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks + chk_m + chk_mon + 1,
                  failures + fail_m + fail_mon + 1);
         $finish;
      end
   end
endmodule